// File: doc/BRIEF.md
# E1 Transmit Channel-Associated Signaling Inserter

This block sits in the transmit path of an E1 framer and runs on the 2.048 MHz bit clock. It carries one bit of the outgoing PCM stream per clock. It rebuilds timeslot 16, the signaling slot, and passes every other bit through unchanged after exactly one clock. A bit counter follows the 4096-bit multiframe, which is 16 frames of 32 timeslots of 8 bits. A pulse on `mf_sync` aligns the counter to the first bit of frame 0.

In frames 1 to 15, timeslot 16 holds two ABCD nibbles. The first nibble belongs to timeslot n and the second to timeslot n+16, where n is the frame number. Each nibble is sourced independently, according to the select bit of its own timeslot. A select bit of 0 takes the nibble from the stream. The stream is the data input, or the separate signaling input when hardware insertion is enabled. A select bit of 1 takes the nibble from that timeslot's signaling register. In frame 0, timeslot 16 carries the multiframe alignment nibble 0000 followed by the spare/alarm nibble from a dedicated register.

A simple write-only configuration port loads the signaling registers, the enable, the select bits and the frame-0 nibble.

Top module: `e1_cas_inserter`

## Requirements
- R1: Every bit outside timeslot 16 appears on `ser_out` one clock after it was presented on `ser_in`, unchanged, whatever the configuration.
- R2: A cycle with `mf_sync` high is bit 0 of timeslot 0 of frame 0. Bits are sent MSB first. The position then advances by one per clock, with timeslot = position[7:3] and frame = position[11:8]. Without a sync pulse the position wraps from 4095 to 0.
- R3: With hardware insertion off (control bit 0 = 0) and a timeslot's select bit at 0, that timeslot's timeslot-16 nibble in frames 1 to 15 comes from `ser_in`.
- R4: With hardware insertion on and a select bit at 0, the nibble comes from `sig_in`, sampled in the same cycle as the corresponding `ser_in` bit would be.
- R5: With select bit n = 1 (n in 1..15), the first nibble of timeslot 16 in frame n is register n, bit 3 (A) sent first.
- R6: With select bit n+16 = 1, the second nibble of timeslot 16 in frame n is register n+16, bit 3 first. The choice for this nibble does not depend on the select bit used for the first nibble.
- R7: With hardware insertion on, timeslot 16 of frame 0 is sent as 0,0,0,0 followed by bits 3,2,1,0 of the frame-0 register (X, Y, X, X, with Y the remote alarm bit).
- R8: With hardware insertion off, timeslot 16 of frame 0 comes from the frame-0 format of R7 when select bit 16 is 1, and from `ser_in` when it is 0.
- R9: A write with `cfg_we` high updates the configuration, and the new value governs the bit presented in the next clock. The address map is as follows. Addresses 0..31 load signaling register `cfg_addr` from `cfg_wdata[3:0]`. Address 32 loads the hardware-insertion enable from `cfg_wdata[0]`. Addresses 33..36 load select bits [7:0], [15:8], [23:16] and [31:24]. Address 37 loads the frame-0 register from `cfg_wdata[3:0]`. Writes to addresses 38..63 change nothing.
- R10: During reset `ser_out` is 0. Reset clears all configuration to 0, so after reset timeslot 16 passes `ser_in` through in every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_sync | input | 1 | Marks the first bit of a multiframe |
| ser_in | input | 1 | Transmit PCM data bit |
| sig_in | input | 1 | Serial signaling bit, used when hardware insertion is on |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| ser_out | output | 1 | PCM output with timeslot 16 rebuilt |

## Verification
The bench aims at the two nibble halves of timeslot 16, using mixed select bits, so that a design which ties the second nibble to the first nibble's select bit, or which swaps the n and n+16 registers, sends wrong bits in frames 1 to 15. It toggles hardware insertion between multiframes to check frame 0. A design that leaves the alignment nibble nonzero, or that ignores select bit 16 when insertion is off, would corrupt that slot. It also writes configuration in the middle of a timeslot and writes to unused addresses. An off-by-one in when a write takes effect, or a decoder that aliases the unused addresses, shows up as a wrong output bit. Resynchronising at random positions and letting the counter run free across a wrap catches counters that ignore the sync pulse or wrap at the wrong length.

// File: rtl/e1_cas_inserter.sv
module e1_cas_inserter #(
  parameter int FRAMES = 16,
  parameter int TSLOTS = 32,
  parameter int SIG_TS = 16,
  parameter int AW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mf_sync,
  input  logic          ser_in,
  input  logic          sig_in,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  output logic          ser_out
);
  localparam int TW     = $clog2(TSLOTS);
  localparam int FW     = $clog2(FRAMES);
  localparam int PW     = FW + TW + 3;
  localparam int NSB    = TSLOTS / 8;
  localparam int A_CTRL = TSLOTS;
  localparam int A_SEL  = TSLOTS + 1;
  localparam int A_F0   = TSLOTS + 1 + NSB;

  logic [PW-1:0]     cnt, pos;
  logic [3:0]        sreg [TSLOTS];
  logic [TSLOTS-1:0] sel;
  logic [3:0]        f0_nib;
  logic              hw_en, primed;

  assign pos = mf_sync ? '0 : cnt;

  logic [2:0]    bi;
  logic [TW-1:0] ts, nib_ts;
  logic [FW-1:0] fr;
  logic          in_sig, upper, stream, f0_bit, ch_bit, nxt;

  assign bi     = pos[2:0];
  assign ts     = pos[TW+2:3];
  assign fr     = pos[PW-1:TW+3];
  assign in_sig = (ts == TW'(SIG_TS));
  assign upper  = !bi[2];
  assign nib_ts = upper ? TW'(fr) : TW'(fr) + TW'(SIG_TS);
  assign stream = hw_en ? sig_in : ser_in;
  assign f0_bit = upper ? 1'b0 : f0_nib[~bi[1:0]];
  assign ch_bit = sreg[nib_ts][~bi[1:0]];

  always_comb begin
    if (!in_sig)
      nxt = ser_in;
    else if (fr == '0)
      nxt = (hw_en || sel[SIG_TS]) ? f0_bit : stream;
    else
      nxt = sel[nib_ts] ? ch_bit : stream;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ser_out <= 1'b0;
      primed  <= 1'b0;
    end else begin
      cnt     <= pos + 1'b1;
      ser_out <= nxt;
      primed  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TSLOTS; i++) sreg[i] <= '0;
      sel    <= '0;
      hw_en  <= 1'b0;
      f0_nib <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < AW'(TSLOTS))
        sreg[cfg_addr[TW-1:0]] <= cfg_wdata[3:0];
      if (cfg_addr == AW'(A_CTRL))
        hw_en <= cfg_wdata[0];
      for (int k = 0; k < NSB; k++)
        if (cfg_addr == AW'(A_SEL + k)) sel[8*k +: 8] <= cfg_wdata;
      if (cfg_addr == AW'(A_F0))
        f0_nib <= cfg_wdata[3:0];
    end
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(!in_sig)) |-> (ser_out == $past(ser_in))); // R1

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(mf_sync)) |-> (cnt == PW'(1))); // R2

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(!mf_sync && cnt == '1)) |-> (cnt == '0)); // R2

  AST_HW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(in_sig && fr != '0 && hw_en && !sel[nib_ts]))
      |-> (ser_out == $past(sig_in))); // R4

  AST_MFAW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(in_sig && fr == '0 && upper && hw_en)) |-> !ser_out); // R7
endmodule

// File: tb/tb_e1_cas_inserter.sv
module tb_e1_cas_inserter;
  logic clk = 0, rst_n = 0, mf_sync = 0, ser_in = 0, sig_in = 0, cfg_we = 0;
  logic [5:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic ser_out;

  e1_cas_inserter dut (.clk(clk), .rst_n(rst_n), .mf_sync(mf_sync), .ser_in(ser_in),
    .sig_in(sig_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ser_out(ser_out));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0]  m_reg [32];
  logic [31:0] m_sel;
  logic [3:0]  m_f0;
  logic        m_hw;
  int          mpos = 0;
  bit          phase_a = 0;

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(int p, logic s, logic g);
    int b = p % 8, t = (p / 8) % 32, f = p / 256;
    int n = (b < 4) ? f : f + 16;
    logic strm = m_hw ? g : s;
    if (t != 16) return s;
    if (f == 0) begin
      if (m_hw || m_sel[16]) return (b < 4) ? 1'b0 : m_f0[7 - b];
      return s;
    end
    return m_sel[n] ? m_reg[n][3 - (b % 4)] : strm;
  endfunction

  function automatic string tag_of(int p);
    int b = p % 8, t = (p / 8) % 32, f = p / 256;
    int n = (b < 4) ? f : f + 16;
    if (t != 16) return "R1";
    if (phase_a) return "R10";
    if (f == 0) return m_hw ? "R7" : "R8";
    if (m_sel[n]) return (b < 4) ? "R5" : "R6";
    return m_hw ? "R4" : "R3";
  endfunction

  task automatic step(input bit sync, input bit we, input logic [5:0] a, input logic [7:0] d);
    int p;
    logic e;
    string tg;
    ser_in = 1'($urandom); sig_in = 1'($urandom);
    mf_sync = sync; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    p = sync ? 0 : mpos;
    e = exp_bit(p, ser_in, sig_in);
    tg = tag_of(p);
    if (sync || p == 0) tg = "R2";
    if (we) begin
      if (a < 32) m_reg[a] = d[3:0];
      else if (a == 32) m_hw = d[0];
      else if (a >= 33 && a <= 36) m_sel[8*(a-33) +: 8] = d;
      else if (a == 37) m_f0 = d[3:0];
    end
    mpos = (p + 1) % 4096;
    @(negedge clk);
    if (we) tg = "R9";
    chk(ser_out, e, tg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R2 watchdog act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1e1c_a5));
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    m_sel = 0; m_f0 = 0; m_hw = 0;
    ser_in = 1;
    repeat (3) begin
      @(negedge clk);
      chk(ser_out, 1'b0, "R10");
    end
    rst_n = 1;
    phase_a = 1;
    step(1, 0, 0, 0);
    for (int i = 1; i < 4096; i++) step(0, 0, 0, 0);
    phase_a = 0;
    step(0, 1, 6'd37, 8'h0b);
    step(0, 1, 6'd32, 8'h01);
    for (int i = 2; i < 4096; i++) step(0, 0, 0, 0);
    step(0, 1, 6'd32, 8'h00);
    step(0, 1, 6'd35, 8'h01);
    for (int i = 2; i < 4096; i++) step(0, 0, 0, 0);
    step(0, 1, 6'd3, 8'h0a);
    step(0, 1, 6'd19, 8'h05);
    step(0, 1, 6'd33, 8'h08);
    step(0, 1, 6'd35, 8'h08);
    step(0, 1, 6'd45, 8'hff);
    for (int i = 5; i < 4096; i++) step(0, 0, 0, 0);
    for (int i = 0; i < 6 * 4096; i++) begin
      bit s = ($urandom % 3000) == 0;
      bit w = ($urandom % 48) == 0;
      step(s, w, 6'($urandom), 8'($urandom));
    end
    for (int i = 0; i < 4200; i++) step(0, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule